// File: doc/BRIEF.md
# Packed Halving Averaging Adder

This block takes two 32-bit operands, splits them into lanes according to a format select, and returns the mean of each pair of lanes. Each lane sum is formed one bit wider than the lane and then shifted right by one bit. Because of that extra bit the halved result always fits back into the lane, so the unit never saturates and raises no flags. Three lane formats are supported: two signed 16-bit lanes, one signed 32-bit lane and four unsigned 8-bit lanes. A round input chooses between dropping the discarded bit and rounding half up, which adds one to the wide sum before the shift.

The result is captured in an output register on every rising clock edge, so a new operand set can be presented each cycle. A synchronous, active-high reset clears that register. Instruction decode and register-file access belong to the surrounding datapath.

Top module: `avg_packed`

## Requirements
- R1: While `rst` is high at a rising edge, `avg_out` becomes all zeros after that edge.
- R2: `avg_out` changes only at a rising clock edge. It reflects the inputs sampled at that edge, which gives one cycle of latency.
- R3: With `fmt_sel` = 2'b00, the operands are two signed 16-bit lanes, with lane 1 in bits [31:16] and lane 0 in bits [15:0]. Each result lane is bits [16:1] of the 17-bit sum of the sign-extended lanes plus the round bit, and it is written to the same bit position.
- R4: With `fmt_sel` = 2'b01, the operands are one signed 32-bit lane. The result is bits [32:1] of the 33-bit sum of the sign-extended operands plus the round bit.
- R5: With `fmt_sel` = 2'b10, the operands are four unsigned 8-bit lanes at bits [8k+7:8k]. Each result lane is bits [8:1] of the 9-bit sum of the zero-extended lanes plus the round bit.
- R6: With `round_en` = 0, the discarded bit is simply dropped, which rounds toward minus infinity. For example, the signed halfwords 0xFFFF and 0x0000 give 0xFFFF, and any signed x with ~x gives all ones.
- R7: With `round_en` = 1, one is added inside the widened sum, so the result cannot wrap. For example, 0x7FFF with 0x7FFF gives 0x7FFF, 0x8000 with 0x8000 gives 0x8000, and any signed x with ~x gives zero.
- R8: Lanes are independent: no carry crosses a lane boundary. For example, bytes 0xFF and 0xFF in lane 0, with zeros elsewhere, give 0x000000FF.
- R9: With `fmt_sel` = 2'b11 (reserved), `avg_out` is all zeros whatever the operands are.
- R10: For any defined format and either round setting, equal operands give that same operand as the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 32 | First packed operand |
| b_in | input | 32 | Second packed operand |
| fmt_sel | input | 2 | Lane format: 00 signed halfwords, 01 signed word, 10 unsigned bytes, 11 reserved |
| round_en | input | 1 | 1 rounds half up, 0 truncates |
| avg_out | output | 32 | Registered packed lane means |

## Verification
Every result is due on the first rising edge after its operands, format and round bit are applied. The bench drives the inputs at the falling edge and reads `avg_out` 1 ns after the next rising edge, so each check sees exactly one register stage. One check reads the output just before that edge to confirm the earlier value still holds. The reset check applies non-zero operands while `rst` is high and expects zeros after the same single edge.

// File: rtl/avg_pkg.sv
package avg_pkg;
  typedef enum logic [1:0] {
    FMT_HALF = 2'b00,
    FMT_WORD = 2'b01,
    FMT_BYTE = 2'b10,
    FMT_NONE = 2'b11
  } avg_fmt_e;
endpackage

// File: rtl/avg_lane.sv
// One lane: widened sum plus round bit, halved back to lane width.
module avg_lane #(
  parameter int W      = 8,
  parameter bit SIGNED = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         rnd_i,
  output logic [W-1:0] y_o
);
  logic [W:0] ext_a;
  logic [W:0] ext_b;
  logic [W:0] total;

  always_comb begin
    ext_a = SIGNED ? {a_i[W-1], a_i} : {1'b0, a_i};
    ext_b = SIGNED ? {b_i[W-1], b_i} : {1'b0, b_i};
    // The extra top bit absorbs the carry, including the round-up.
    total = ext_a + ext_b + {{W{1'b0}}, rnd_i};
    y_o   = W'(total >> 1);
  end
endmodule

// File: rtl/avg_lane_bank.sv
// A row of independent lanes covering LANES*LANE_W bits.
module avg_lane_bank #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter bit SIGNED = 1'b0,
  localparam int TOT_W = LANE_W * LANES
) (
  input  logic [TOT_W-1:0] a_i,
  input  logic [TOT_W-1:0] b_i,
  input  logic             rnd_i,
  output logic [TOT_W-1:0] y_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    avg_lane #(.W(LANE_W), .SIGNED(SIGNED)) u_lane (
      .a_i  (a_i[k*LANE_W +: LANE_W]),
      .b_i  (b_i[k*LANE_W +: LANE_W]),
      .rnd_i(rnd_i),
      .y_o  (y_o[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/avg_packed.sv
module avg_packed #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [1:0]        fmt_sel,
  input  logic              round_en,
  output logic [DATA_W-1:0] avg_out
);
  import avg_pkg::*;

  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = DATA_W / 4;

  logic [DATA_W-1:0] half_y;
  logic [DATA_W-1:0] word_y;
  logic [DATA_W-1:0] byte_y;
  logic [DATA_W-1:0] next_y;

  avg_lane_bank #(.LANE_W(HALF_W), .LANES(2), .SIGNED(1'b1)) u_half (
    .a_i(a_in), .b_i(b_in), .rnd_i(round_en), .y_o(half_y)
  );

  avg_lane_bank #(.LANE_W(DATA_W), .LANES(1), .SIGNED(1'b1)) u_word (
    .a_i(a_in), .b_i(b_in), .rnd_i(round_en), .y_o(word_y)
  );

  avg_lane_bank #(.LANE_W(BYTE_W), .LANES(4), .SIGNED(1'b0)) u_byte (
    .a_i(a_in), .b_i(b_in), .rnd_i(round_en), .y_o(byte_y)
  );

  always_comb begin
    case (avg_fmt_e'(fmt_sel))
      FMT_HALF: next_y = half_y;
      FMT_WORD: next_y = word_y;
      FMT_BYTE: next_y = byte_y;
      default:  next_y = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) avg_out <= '0;
    else     avg_out <= next_y;
  end
endmodule

// File: rtl/avg_packed_chk.sv
module avg_packed_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] b_in,
  input logic [1:0]        fmt_sel,
  input logic              round_en,
  input logic [DATA_W-1:0] avg_out
);
  localparam logic [DATA_W-1:0] BYTES_LO = {(DATA_W/8){8'h7F}};
  localparam logic [DATA_W-1:0] BYTES_HI = {(DATA_W/8){8'h80}};

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (avg_out == '0));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (fmt_sel == 2'b11) |=> (avg_out == '0));

  p_equal_mean_r10: assert property (@(posedge clk) disable iff (rst)
    (fmt_sel != 2'b11 && a_in == b_in) |=> (avg_out == $past(a_in)));

  // signed x with ~x sums to -1: floor half is -1 (R6), rounded half is 0 (R7)
  p_cmpl_trunc_r6: assert property (@(posedge clk) disable iff (rst)
    (fmt_sel[1] == 1'b0 && !round_en && b_in == ~a_in) |=> (avg_out == '1));

  p_cmpl_round_r7: assert property (@(posedge clk) disable iff (rst)
    (fmt_sel[1] == 1'b0 && round_en && b_in == ~a_in) |=> (avg_out == '0));

  p_cmpl_byte_r5: assert property (@(posedge clk) disable iff (rst)
    (fmt_sel == 2'b10 && b_in == ~a_in) |=>
      (avg_out == ($past(round_en) ? BYTES_HI : BYTES_LO)));
endmodule

bind avg_packed avg_packed_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
  .fmt_sel(fmt_sel), .round_en(round_en), .avg_out(avg_out)
);

// File: tb/avg_packed_test.sv
`timescale 1ns/1ps
module avg_packed_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a_in = '0;
  logic [31:0] b_in = '0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        round_en = 1'b0;
  logic [31:0] avg_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  avg_packed #(.DATA_W(32)) uut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .fmt_sel(fmt_sel), .round_en(round_en), .avg_out(avg_out)
  );

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [1:0] f, input logic r);
    logic [31:0] y;
    longint s;
    y = '0;
    case (f)
      2'b00: for (int k = 0; k < 2; k++) begin
        s = longint'($signed(a[k*16 +: 16])) + longint'($signed(b[k*16 +: 16])) + longint'(r);
        s = s >>> 1;
        y[k*16 +: 16] = s[15:0];
      end
      2'b01: begin
        s = longint'($signed(a)) + longint'($signed(b)) + longint'(r);
        s = s >>> 1;
        y = s[31:0];
      end
      2'b10: for (int k = 0; k < 4; k++) begin
        s = longint'(a[k*8 +: 8]) + longint'(b[k*8 +: 8]) + longint'(r);
        s = s >>> 1;
        y[k*8 +: 8] = s[7:0];
      end
      default: y = '0;
    endcase
    return y;
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  // drive at falling edge, read 1 ns after the next rising edge
  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] f, input logic r);
    @(negedge clk);
    a_in = a; b_in = b; fmt_sel = f; round_en = r;
    @(posedge clk);
    #1;
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b,
                     input logic [1:0] f, input logic r, input string tag);
    apply(a, b, f, r);
    check(avg_out, model(a, b, f, r), tag);
  endtask

  task automatic run_exp(input logic [31:0] a, input logic [31:0] b, input logic [1:0] f,
                         input logic r, input logic [31:0] exp, input string tag);
    apply(a, b, f, r);
    check(avg_out, exp, tag);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] corner_h [8];
    logic [31:0] corner_w [8];
    logic [31:0] prev;
    corner_h = '{32'h0000, 32'h0001, 32'h7FFF, 32'h8000, 32'h8001, 32'hFFFF, 32'h4000, 32'hC000};
    corner_w = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'h80000001,
                 32'hFFFFFFFF, 32'h40000000, 32'hC0000000};

    // R1: reset with non-zero operands
    @(negedge clk);
    a_in = 32'h12345678; b_in = 32'h7FFF7FFF; fmt_sel = 2'b10; round_en = 1'b1;
    repeat (2) @(posedge clk);
    #1 check(avg_out, 32'h0, "R1 reset");
    @(negedge clk) rst = 1'b0;

    // R2: output holds until the edge, then updates
    run(32'h10203040, 32'h30405060, 2'b10, 1'b0, "R2 first");
    prev = avg_out;
    @(negedge clk);
    a_in = 32'hFFFF0002; b_in = 32'h00030004; fmt_sel = 2'b00; round_en = 1'b1;
    #1 check(avg_out, prev, "R2 hold before edge");
    @(posedge clk);
    #1 check(avg_out, model(32'hFFFF0002, 32'h00030004, 2'b00, 1'b1), "R2 after edge");

    // R3: halfword corners in both lanes, both round settings
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int r = 0; r < 2; r++)
          run({corner_h[i][15:0], corner_h[j][15:0]},
              {corner_h[j][15:0], corner_h[(i+3)%8][15:0]}, 2'b00, r[0], "R3 halfword corner");
    for (int n = 0; n < 1500; n++)
      run($urandom, $urandom, 2'b00, n[0], "R3 halfword random");

    // R4: word corners and random
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int r = 0; r < 2; r++)
          run(corner_w[i], corner_w[j], 2'b01, r[0], "R4 word corner");
    for (int n = 0; n < 1500; n++)
      run($urandom, $urandom, 2'b01, n[0], "R4 word random");

    // R5: byte sweep, every a value against a stride of b values in all lanes
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y += 3)
        for (int r = 0; r < 2; r++)
          run({x[7:0], y[7:0], x[7:0] ^ 8'h5A, y[7:0] + x[7:0]},
              {y[7:0], x[7:0], ~y[7:0], x[7:0] ^ 8'hC3}, 2'b10, r[0], "R5 byte sweep");

    // R6: truncation rounds toward minus infinity
    run_exp(32'h0000FFFF, 32'h00000000, 2'b00, 1'b0, 32'h0000FFFF, "R6 floor halfword");
    run_exp(32'hFFFFFFFF, 32'h00000000, 2'b01, 1'b0, 32'hFFFFFFFF, "R6 floor word");
    run_exp(32'h00000003, 32'h00000000, 2'b10, 1'b0, 32'h00000001, "R6 floor byte");
    run_exp(32'h12345678, ~32'h12345678, 2'b00, 1'b0, 32'hFFFFFFFF, "R6 complement");

    // R7: rounding inside the widened sum
    run_exp(32'h7FFF7FFF, 32'h7FFF7FFF, 2'b00, 1'b1, 32'h7FFF7FFF, "R7 max halfword");
    run_exp(32'h80008000, 32'h80008000, 2'b00, 1'b1, 32'h80008000, "R7 min halfword");
    run_exp(32'h7FFFFFFF, 32'h7FFFFFFF, 2'b01, 1'b1, 32'h7FFFFFFF, "R7 max word");
    run_exp(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b10, 1'b1, 32'hFFFFFFFF, "R7 max byte");
    run_exp(32'h00000003, 32'h00000000, 2'b10, 1'b1, 32'h00000002, "R7 round up byte");
    run_exp(32'h0000FFFF, 32'h00000000, 2'b00, 1'b1, 32'h00000000, "R7 round halfword");
    run_exp(32'h12345678, ~32'h12345678, 2'b01, 1'b1, 32'h00000000, "R7 complement");

    // R8: no carry across lanes
    run_exp(32'h000000FF, 32'h000000FF, 2'b10, 1'b1, 32'h000000FF, "R8 byte isolation");
    run_exp(32'h0000FFFF, 32'h0000FFFF, 2'b00, 1'b0, 32'h0000FFFF, "R8 halfword isolation");
    run_exp(32'h00008000, 32'h00008000, 2'b00, 1'b0, 32'h00008000, "R8 halfword sign stays");

    // R9: reserved format
    run_exp(32'hDEADBEEF, 32'h01234567, 2'b11, 1'b0, 32'h0, "R9 reserved");
    run_exp(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b11, 1'b1, 32'h0, "R9 reserved round");

    // R10: equal operands
    for (int f = 0; f < 3; f++)
      for (int r = 0; r < 2; r++)
        run_exp(32'h8F01_7EA5, 32'h8F01_7EA5, f[1:0], r[0], 32'h8F01_7EA5, "R10 equal operands");

    // R1 again mid-run
    @(negedge clk);
    rst = 1'b1; a_in = 32'h7FFF7FFF; b_in = 32'h7FFF7FFF; fmt_sel = 2'b00;
    @(posedge clk);
    #1 check(avg_out, 32'h0, "R1 mid-run reset");
    @(negedge clk) rst = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule